// File: doc/BRIEF.md
# Injected Instruction Priority Arbiter

This block chooses the next instruction for a small I/O state machine. There are three candidates. A host can force an instruction. The running program can inject an instruction through an execute command, and the host can also write that slot. Otherwise the next word is taken from the 32-entry instruction memory at the address the program counter presents.

Each injection slot holds a 16-bit opcode and a pending flag. A separate cancel strobe empties each slot, but only while the held instruction has not started fetch and decode.

An instruction is issued, which counts as fetch starting, in any cycle where the state-machine clock enable and the decoder's ready handshake are both high. On every issue the block records two things for the instruction now executing: its origin category and, for memory instructions, the memory address it came from. The decoder and the PC logic are outside the block and use these reports.

Top module: `inj_issue_arb`

## Requirements
- R1: After reset both slots are empty, both opcode views read 0x0000, the origin category reads 1 and the origin address reads 0.
- R2: An issue happens only in a cycle where `clk_en` and `dec_ready` are both high. In any other cycle `issue_vld` is low and a pending slot keeps its opcode and pending flag.
- R3: On issue, a pending forced instruction goes first, then a pending execute-command instruction, then the memory word. `issue_src` encodes the source as 3 (forced), 2 (execute command) or 1 (memory). A slot that is not chosen stays pending.
- R4: A write to a slot sets its pending flag. The slot's opcode view then shows the written opcode, and it reads 0x0000 while the slot is empty. A slot empties when its instruction issues.
- R5: A forced write while a forced instruction is already pending replaces the held opcode.
- R6: A cancel strobe in a cycle where its slot does not issue empties the slot. A later issue then takes the next source in priority order.
- R7: A cancel strobe in the same cycle as the issue of its own slot has no effect: the instruction issues with its opcode, and the slot is empty afterwards.
- R8: One cycle after an issue, `origin_cat` holds that issue's source code (3, 2 or 1). It keeps that value through cycles without an issue.
- R9: One cycle after a memory issue, `origin_addr` holds the `pc` value of the issue cycle. It does not follow later changes of `pc`, and injected issues leave it unchanged.
- R10: A write to a slot in the same cycle as that slot's cancel or issue leaves the slot pending with the newly written opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | State-machine clock enable |
| dec_ready | input | 1 | Decoder can start a new instruction |
| frc_wr | input | 1 | Host writes the forced slot |
| frc_op | input | 16 | Forced opcode |
| exe_wr | input | 1 | Execute command or host writes the execute slot |
| exe_op | input | 16 | Execute-command opcode |
| frc_cancel | input | 1 | Cancel strobe for the forced slot |
| exe_cancel | input | 1 | Cancel strobe for the execute slot |
| pc | input | 5 | Program counter, address of `mem_op` |
| mem_op | input | 16 | Instruction memory word at `pc` |
| issue_vld | output | 1 | An instruction starts fetch and decode this cycle |
| issue_op | output | 16 | Opcode being issued |
| issue_src | output | 2 | Source of the issued opcode (3, 2 or 1), 0 when idle |
| frc_pend | output | 1 | Forced slot holds an instruction |
| frc_view | output | 16 | Forced opcode, zero when empty |
| exe_pend | output | 1 | Execute slot holds an instruction |
| exe_view | output | 16 | Execute opcode, zero when empty |
| origin_cat | output | 2 | Category of the executing instruction |
| origin_addr | output | 5 | Memory address of the executing memory instruction |

## Verification
The hardest cases to reach are the collisions inside one issue cycle: a cancel or a write landing on the slot that is being issued, and a cancel of the execute slot while the forced slot wins. To set these up, the stimulus fills both slots during cycles where the clock enable or decoder ready is held low. It then opens the issue gate for exactly the cycle that carries the colliding strobe. A scoreboard pairs every expected issue with the source and opcode the design produces, and checks the origin report one cycle later.

// File: rtl/inj_issue_arb.sv
module inj_issue_arb #(
  parameter int OP_W   = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              dec_ready,
  input  logic              frc_wr,
  input  logic [OP_W-1:0]   frc_op,
  input  logic              exe_wr,
  input  logic [OP_W-1:0]   exe_op,
  input  logic              frc_cancel,
  input  logic              exe_cancel,
  input  logic [ADDR_W-1:0] pc,
  input  logic [OP_W-1:0]   mem_op,
  output logic              issue_vld,
  output logic [OP_W-1:0]   issue_op,
  output logic [1:0]        issue_src,
  output logic              frc_pend,
  output logic [OP_W-1:0]   frc_view,
  output logic              exe_pend,
  output logic [OP_W-1:0]   exe_view,
  output logic [1:0]        origin_cat,
  output logic [ADDR_W-1:0] origin_addr
);
  localparam logic [1:0] SRC_NONE = 2'd0;
  localparam logic [1:0] SRC_MEM  = 2'd1;
  localparam logic [1:0] SRC_EXE  = 2'd2;
  localparam logic [1:0] SRC_FRC  = 2'd3;

  logic [OP_W-1:0] frc_q, exe_q;
  logic            take_frc, take_exe;

  assign issue_vld = clk_en & dec_ready;
  assign take_frc  = issue_vld & frc_pend;
  assign take_exe  = issue_vld & ~frc_pend & exe_pend;

  assign issue_op  = take_frc ? frc_q : take_exe ? exe_q : mem_op;
  assign issue_src = !issue_vld ? SRC_NONE :
                     take_frc   ? SRC_FRC  :
                     take_exe   ? SRC_EXE  : SRC_MEM;

  assign frc_view = frc_pend ? frc_q : '0;
  assign exe_view = exe_pend ? exe_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frc_pend <= 1'b0;
      exe_pend <= 1'b0;
      frc_q    <= '0;
      exe_q    <= '0;
    end else begin
      if (frc_wr) begin
        frc_pend <= 1'b1;
        frc_q    <= frc_op;
      end else if (take_frc || frc_cancel) begin
        frc_pend <= 1'b0;
      end
      if (exe_wr) begin
        exe_pend <= 1'b1;
        exe_q    <= exe_op;
      end else if (take_exe || exe_cancel) begin
        exe_pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      origin_cat  <= SRC_MEM;
      origin_addr <= '0;
    end else if (issue_vld) begin
      origin_cat <= issue_src;
      if (issue_src == SRC_MEM) origin_addr <= pc;
    end
  end
endmodule

// File: rtl/inj_issue_arb_chk.sv
module inj_issue_arb_chk #(
  parameter int OP_W   = 16,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              dec_ready,
  input logic              frc_wr,
  input logic [OP_W-1:0]   frc_op,
  input logic              exe_wr,
  input logic              frc_cancel,
  input logic              exe_cancel,
  input logic [ADDR_W-1:0] pc,
  input logic              issue_vld,
  input logic [1:0]        issue_src,
  input logic              frc_pend,
  input logic [OP_W-1:0]   frc_view,
  input logic              exe_pend,
  input logic [1:0]        origin_cat,
  input logic [ADDR_W-1:0] origin_addr
);
  AST_HOLD_WHEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_en && dec_ready) && frc_pend && !frc_wr && !frc_cancel |=> frc_pend); // R2

  AST_EXE_WAITS_FOR_FRC: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld && frc_pend && exe_pend && !exe_wr && !exe_cancel |=> exe_pend); // R3

  AST_FRC_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    frc_wr |=> frc_pend && frc_view == $past(frc_op)); // R10

  AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    frc_cancel && !issue_vld && !frc_wr |=> !frc_pend); // R6

  AST_CAT_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld && frc_pend |=> origin_cat == 2'd3); // R8

  AST_CAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_vld |=> $stable(origin_cat)); // R8

  AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld && issue_src == 2'd1 |=> origin_addr == $past(pc)); // R9

  AST_ADDR_HOLDS_INJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld && issue_src != 2'd1 |=> $stable(origin_addr)); // R9
endmodule

bind inj_issue_arb inj_issue_arb_chk #(.OP_W(OP_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .dec_ready(dec_ready),
  .frc_wr(frc_wr), .frc_op(frc_op), .exe_wr(exe_wr),
  .frc_cancel(frc_cancel), .exe_cancel(exe_cancel), .pc(pc),
  .issue_vld(issue_vld), .issue_src(issue_src), .frc_pend(frc_pend),
  .frc_view(frc_view), .exe_pend(exe_pend), .origin_cat(origin_cat),
  .origin_addr(origin_addr)
);

// File: tb/inj_issue_arb_tb.sv
module inj_issue_arb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b0, dec_ready = 1'b0;
  logic        frc_wr = 1'b0, exe_wr = 1'b0, frc_cancel = 1'b0, exe_cancel = 1'b0;
  logic [15:0] frc_op = '0, exe_op = '0, mem_op = '0;
  logic [4:0]  pc = '0;
  logic        issue_vld, frc_pend, exe_pend;
  logic [15:0] issue_op, frc_view, exe_view;
  logic [1:0]  issue_src, origin_cat;
  logic [4:0]  origin_addr;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [15:0] q_op[$];
  logic [1:0]  q_src[$];
  logic [4:0]  q_addr[$];

  always #5 clk = ~clk;

  inj_issue_arb dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .dec_ready(dec_ready),
    .frc_wr(frc_wr), .frc_op(frc_op), .exe_wr(exe_wr), .exe_op(exe_op),
    .frc_cancel(frc_cancel), .exe_cancel(exe_cancel), .pc(pc), .mem_op(mem_op),
    .issue_vld(issue_vld), .issue_op(issue_op), .issue_src(issue_src),
    .frc_pend(frc_pend), .frc_view(frc_view), .exe_pend(exe_pend),
    .exe_view(exe_view), .origin_cat(origin_cat), .origin_addr(origin_addr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle of stimulus, called at posedge+2; returns at next posedge+2
  task automatic cyc(input bit ce, input bit dr, input bit fw, input logic [15:0] fo,
                     input bit ew, input logic [15:0] eo, input bit fc, input bit ec,
                     input logic [4:0] p, input logic [15:0] mo);
    clk_en = ce; dec_ready = dr; frc_wr = fw; frc_op = fo; exe_wr = ew; exe_op = eo;
    frc_cancel = fc; exe_cancel = ec; pc = p; mem_op = mo;
    @(posedge clk); #2;
  endtask

  task automatic expect_issue(input logic [15:0] op, input logic [1:0] src, input logic [4:0] a);
    q_op.push_back(op); q_src.push_back(src); q_addr.push_back(a);
  endtask

  // monitor: compares issues against the scoreboard, then the origin report one cycle later
  logic        org_chk = 0;
  logic [1:0]  org_src;
  logic [4:0]  org_addr;
  always @(negedge clk) begin
    if (rst_n) begin
      if (org_chk) begin
        chk(origin_cat == org_src, "R8 origin_cat", origin_cat, org_src);
        chk(origin_addr == org_addr, "R9 origin_addr", origin_addr, org_addr);
        org_chk = 0;
      end
      chk(issue_vld == (clk_en && dec_ready), "R2 issue gate", issue_vld, clk_en && dec_ready);
      if (issue_vld) begin
        if (q_op.size() == 0) begin
          chk(0, "R3 unexpected issue", issue_op, 0);
        end else begin
          logic [15:0] eop; logic [1:0] esrc; logic [4:0] ea;
          eop = q_op.pop_front(); esrc = q_src.pop_front(); ea = q_addr.pop_front();
          chk(issue_src == esrc, "R3 issue_src", issue_src, esrc);
          chk(issue_op == eop, "R3 issue_op", issue_op, eop);
          org_src = esrc; org_addr = ea; org_chk = 1;
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(frc_pend == 0 && exe_pend == 0, "R1 pending after reset", {frc_pend, exe_pend}, 0);
    chk(frc_view == 0 && exe_view == 0, "R1 views after reset", {frc_view, exe_view}, 0);
    chk(origin_cat == 1, "R1 origin_cat after reset", origin_cat, 1);
    chk(origin_addr == 0, "R1 origin_addr after reset", origin_addr, 0);
    rst_n = 1;
    @(posedge clk); #2;

    // memory issue
    expect_issue(16'hAAAA, 1, 5);
    cyc(1,1, 0,0, 0,0, 0,0, 5,16'hAAAA);
    // R2 gated: forced write while clk_en low, then decoder busy
    cyc(0,1, 1,16'h1111, 0,0, 0,0, 6,16'h0);
    cyc(0,1, 0,0, 0,0, 0,0, 6,16'h0);
    chk(frc_pend == 1 && frc_view == 16'h1111, "R4 forced view", frc_view, 16'h1111);
    cyc(1,0, 0,0, 0,0, 0,0, 6,16'h0);
    chk(frc_pend == 1, "R2 forced held while decoder busy", frc_pend, 1);
    expect_issue(16'h1111, 3, 5);
    cyc(1,1, 0,0, 0,0, 0,0, 6,16'h0BAD);
    chk(frc_pend == 0 && frc_view == 0, "R4 forced slot empties on issue", frc_view, 0);

    // R3 priority with both slots full
    cyc(0,0, 1,16'h2222, 1,16'h3333, 0,0, 6,16'h0);
    expect_issue(16'h2222, 3, 5);
    cyc(1,1, 0,0, 0,0, 0,0, 6,16'h0BAD);
    chk(exe_pend == 1 && exe_view == 16'h3333, "R3 execute slot waits", exe_view, 16'h3333);
    expect_issue(16'h3333, 2, 5);
    cyc(1,1, 0,0, 0,0, 0,0, 6,16'h0BAD);
    expect_issue(16'h4444, 1, 7);
    cyc(1,1, 0,0, 0,0, 0,0, 7,16'h4444);
    cyc(0,0, 0,0, 0,0, 0,0, 8,16'h0);
    chk(origin_addr == 7, "R9 address differs from advanced pc", origin_addr, 7);

    // R5 replacement
    cyc(0,0, 1,16'h5555, 0,0, 0,0, 8,16'h0);
    cyc(0,0, 1,16'h6666, 0,0, 0,0, 8,16'h0);
    chk(frc_view == 16'h6666, "R5 forced replaced", frc_view, 16'h6666);
    expect_issue(16'h6666, 3, 7);
    cyc(1,1, 0,0, 0,0, 0,0, 8,16'h0BAD);
    expect_issue(16'h0808, 1, 8);
    cyc(1,1, 0,0, 0,0, 0,0, 8,16'h0808);

    // R6 cancels while idle
    cyc(0,0, 1,16'h7777, 1,16'h7878, 0,0, 9,16'h0);
    cyc(0,0, 0,0, 0,0, 1,0, 9,16'h0);
    chk(frc_pend == 0 && frc_view == 0, "R6 forced cancelled", frc_view, 0);
    chk(exe_pend == 1, "R6 execute untouched by forced cancel", exe_pend, 1);
    cyc(0,1, 0,0, 0,0, 0,1, 9,16'h0);
    chk(exe_pend == 0 && exe_view == 0, "R6 execute cancelled", exe_view, 0);
    expect_issue(16'h0909, 1, 9);
    cyc(1,1, 0,0, 0,0, 0,0, 9,16'h0909);

    // R7 cancel in own issue cycle
    cyc(0,0, 0,0, 1,16'h8888, 0,0, 10,16'h0);
    expect_issue(16'h8888, 2, 9);
    cyc(1,1, 0,0, 0,0, 0,1, 10,16'h0BAD);
    chk(exe_pend == 0, "R7 execute slot empty after issue", exe_pend, 0);
    // R6 execute cancel while forced issues: execute discarded
    cyc(0,0, 1,16'h9999, 1,16'hA0A0, 0,0, 11,16'h0);
    expect_issue(16'h9999, 3, 9);
    cyc(1,1, 0,0, 0,0, 0,1, 11,16'h0BAD);
    chk(exe_pend == 0, "R6 execute cancelled while forced issues", exe_pend, 0);
    expect_issue(16'h0B0B, 1, 11);
    cyc(1,1, 0,0, 0,0, 0,0, 11,16'h0B0B);

    // R10 write during own issue and during own cancel
    cyc(0,0, 0,0, 1,16'hBBBB, 0,0, 12,16'h0);
    expect_issue(16'hBBBB, 2, 11);
    cyc(1,1, 0,0, 1,16'hCCCC, 0,0, 12,16'h0BAD);
    chk(exe_pend == 1 && exe_view == 16'hCCCC, "R10 write during issue", exe_view, 16'hCCCC);
    expect_issue(16'hCCCC, 2, 11);
    cyc(1,1, 0,0, 0,0, 0,0, 12,16'h0BAD);
    cyc(0,0, 1,16'hDDDD, 0,0, 1,0, 12,16'h0);
    chk(frc_pend == 1 && frc_view == 16'hDDDD, "R10 write beats cancel", frc_view, 16'hDDDD);
    expect_issue(16'hDDDD, 3, 11);
    cyc(1,1, 0,0, 0,0, 0,0, 12,16'h0BAD);
    cyc(0,0, 0,0, 0,0, 0,0, 12,16'h0);
    cyc(0,0, 0,0, 0,0, 0,0, 12,16'h0);

    chk(q_op.size() == 0, "R3 all expected issues seen", q_op.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule